// File: doc/BRIEF.md
# Broadcast/multicast storm limiter

This block sits in the ingress path of a multi-port switch. It limits how many broadcast frames and how many multicast frames each port may let through in each fixed time window. The window length comes from one prescale value shared by all ports and is counted in core clock cycles. Each port has its own 8-bit budget for broadcast and its own 8-bit budget for multicast. The admitted rate for one port and class is therefore (core clock / prescale) × budget frames per second. With a 1 ms window that is 1000 to 255000 frames per second.

For each arriving frame, the frame classifier upstream presents a port number and a class code. The block answers with an admit or drop decision one cycle later. For a dropped frame it also raises a one-cycle drop pulse for that port and class, which statistics logic can count. Budgets are written one port at a time through a register-style write strobe. A global switch turns all limiting off.

Top module: `storm_limiter`

## Requirements
- R1: While reset is held, dec_valid and every drop pulse are 0. Reset leaves every budget at zero and every window count cleared, so with no budget written, all frames are admitted.
- R2: While cfg_enable is 0, every frame is admitted and no drop pulse appears.
- R3: A budget of zero for a port and class means frames of that class on that port are always admitted, even with cfg_enable set.
- R4: With cfg_enable set and budget L > 0, the first L frames of a class on a port within one window are admitted. Later frames of that class on that port in the same window are dropped, and a dropped frame does not use up budget.
- R5: The broadcast budget (class 2'b01) and the multicast budget (class 2'b10) are counted separately, and each port is counted separately.
- R6: Let Peff be cfg_prescale, with 0 taken as 1. The first clock edge after reset is released is cycle 0. Cycle k is a window boundary when (k+1) mod Peff = 0. On a boundary every port and class count restarts at zero in the same cycle.
- R7: A frame presented in a boundary cycle is judged against the cleared count and is counted in the new window.
- R8: A cfg_prescale of 0 behaves as 1: every cycle starts a new window, so every frame under a non-zero budget is admitted.
- R9: Class codes 2'b00 (unicast) and 2'b11 (other) are always admitted and leave all counts unchanged.
- R10: The decision for a frame presented in cycle k appears in cycle k+1: dec_valid is 1 and dec_admit holds the decision. A dropped frame raises exactly one bit in cycle k+1: bit frm_port of drop_bc_pulse or of drop_mc_pulse, matching its class. No drop bit is raised otherwise.
- R11: A budget write in cycle k applies to frames from cycle k+1 on. A frame in cycle k itself is judged against the old budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Global limiting switch |
| cfg_prescale | input | PRESCALE_W | Window length in cycles, 0 taken as 1 |
| cfg_wr_en | input | 1 | Budget write strobe |
| cfg_wr_port | input | PORT_W | Port whose budgets are written |
| cfg_wr_bc_limit | input | LIMIT_W | New broadcast budget |
| cfg_wr_mc_limit | input | LIMIT_W | New multicast budget |
| frm_valid | input | 1 | A frame is presented this cycle |
| frm_port | input | PORT_W | Ingress port of the frame |
| frm_class | input | 2 | 00 unicast, 01 broadcast, 10 multicast, 11 other |
| dec_valid | output | 1 | Decision valid, one cycle after the frame |
| dec_admit | output | 1 | 1 = admit, 0 = drop |
| drop_bc_pulse | output | NUM_PORTS | One-cycle broadcast drop pulse per port |
| drop_mc_pulse | output | NUM_PORTS | One-cycle multicast drop pulse per port |

## Verification
Every decision and drop pulse is registered once, so the result for a frame driven before edge k is sampled at the falling edge after edge k. The bench drives on falling edges and checks on the next falling edge. Its model is stepped once per cycle and applies the R6 boundary formula to the cycle index of the edge being driven. Budget writes enter the model only after that cycle's decision has been computed, so the one-cycle delay of R11 is reproduced without any probe into the design. The prescale value is changed only under reset, which keeps the cycle index of the boundaries fixed.

// File: rtl/storm_pkg.sv
package storm_pkg;
  typedef enum logic [1:0] {
    CLS_UNI = 2'b00,
    CLS_BC  = 2'b01,
    CLS_MC  = 2'b10,
    CLS_OTH = 2'b11
  } frame_class_e;
endpackage

// File: rtl/storm_prescaler.sv
module storm_prescaler #(
  parameter int PRESCALE_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [PRESCALE_W-1:0] prescale,
  output logic                  win_tick
);
  logic [PRESCALE_W-1:0] cnt;
  logic [PRESCALE_W-1:0] last;

  // a zero prescale behaves as one: every cycle is a boundary
  always_comb begin
    last     = (prescale == '0) ? '0 : prescale - PRESCALE_W'(1);
    win_tick = (cnt >= last);
  end

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (win_tick) cnt <= '0;
    else               cnt <= cnt + PRESCALE_W'(1);
  end
endmodule

// File: rtl/storm_limit_regs.sv
module storm_limit_regs #(
  parameter int NUM_PORTS = 4,
  parameter int LIMIT_W   = 8,
  parameter int PORT_W    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [PORT_W-1:0]  wr_port,
  input  logic [LIMIT_W-1:0] wr_bc,
  input  logic [LIMIT_W-1:0] wr_mc,
  input  logic [PORT_W-1:0]  rd_port,
  output logic [LIMIT_W-1:0] rd_bc,
  output logic [LIMIT_W-1:0] rd_mc
);
  localparam logic [PORT_W:0] PORT_CNT = (PORT_W+1)'(NUM_PORTS);

  logic [LIMIT_W-1:0] bc_mem [NUM_PORTS];
  logic [LIMIT_W-1:0] mc_mem [NUM_PORTS];
  logic               wr_ok, rd_ok;

  assign wr_ok = ({1'b0, wr_port} < PORT_CNT);
  assign rd_ok = ({1'b0, rd_port} < PORT_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PORTS; i++) begin
        bc_mem[i] <= '0;
        mc_mem[i] <= '0;
      end
    end else if (wr_en && wr_ok) begin
      bc_mem[wr_port] <= wr_bc;
      mc_mem[wr_port] <= wr_mc;
    end
  end

  // an out-of-range port reads as zero budget, i.e. unlimited
  assign rd_bc = rd_ok ? bc_mem[rd_port] : '0;
  assign rd_mc = rd_ok ? mc_mem[rd_port] : '0;
endmodule

// File: rtl/storm_class_counter.sv
module storm_class_counter #(
  parameter int NUM_PORTS = 4,
  parameter int LIMIT_W   = 8,
  parameter int PORT_W    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               win_tick,
  input  logic               enable,
  input  logic               hit,
  input  logic [PORT_W-1:0]  port,
  input  logic [LIMIT_W-1:0] limit,
  output logic               drop
);
  logic [LIMIT_W-1:0] cnt [NUM_PORTS];
  logic [LIMIT_W-1:0] cur;
  logic               limited;
  logic               under;

  always_comb begin
    cur     = win_tick ? '0 : cnt[port];
    limited = enable && (limit != '0);
    under   = (cur < limit);
    drop    = hit && limited && !under;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PORTS; i++) cnt[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_PORTS; i++) begin
        if (win_tick) cnt[i] <= '0;
        if (hit && limited && under && (port == PORT_W'(i)))
          cnt[i] <= cur + LIMIT_W'(1);
      end
    end
  end
endmodule

// File: rtl/storm_limiter.sv
module storm_limiter
  import storm_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int LIMIT_W    = 8,
  parameter int PRESCALE_W = 16,
  localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_enable,
  input  logic [PRESCALE_W-1:0] cfg_prescale,
  input  logic                  cfg_wr_en,
  input  logic [PORT_W-1:0]     cfg_wr_port,
  input  logic [LIMIT_W-1:0]    cfg_wr_bc_limit,
  input  logic [LIMIT_W-1:0]    cfg_wr_mc_limit,
  input  logic                  frm_valid,
  input  logic [PORT_W-1:0]     frm_port,
  input  logic [1:0]            frm_class,
  output logic                  dec_valid,
  output logic                  dec_admit,
  output logic [NUM_PORTS-1:0]  drop_bc_pulse,
  output logic [NUM_PORTS-1:0]  drop_mc_pulse
);
  localparam int NUM_CLS = 2;   // index 0 broadcast, 1 multicast

  logic               win_tick;
  logic [LIMIT_W-1:0] lim_bc, lim_mc;
  logic [LIMIT_W-1:0] cls_limit [NUM_CLS];
  logic [NUM_CLS-1:0] cls_hit, cls_drop;
  logic [NUM_PORTS-1:0] port_bit;

  storm_prescaler #(.PRESCALE_W(PRESCALE_W)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .prescale (cfg_prescale),
    .win_tick (win_tick)
  );

  storm_limit_regs #(.NUM_PORTS(NUM_PORTS), .LIMIT_W(LIMIT_W), .PORT_W(PORT_W)) u_lim (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_wr_en),
    .wr_port (cfg_wr_port),
    .wr_bc   (cfg_wr_bc_limit),
    .wr_mc   (cfg_wr_mc_limit),
    .rd_port (frm_port),
    .rd_bc   (lim_bc),
    .rd_mc   (lim_mc)
  );

  assign cls_limit[0] = lim_bc;
  assign cls_limit[1] = lim_mc;
  assign cls_hit[0]   = frm_valid && (frm_class == CLS_BC);
  assign cls_hit[1]   = frm_valid && (frm_class == CLS_MC);

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_cls
    storm_class_counter #(.NUM_PORTS(NUM_PORTS), .LIMIT_W(LIMIT_W), .PORT_W(PORT_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .win_tick (win_tick),
      .enable   (cfg_enable),
      .hit      (cls_hit[g]),
      .port     (frm_port),
      .limit    (cls_limit[g]),
      .drop     (cls_drop[g])
    );
  end

  assign port_bit = NUM_PORTS'(1) << frm_port;

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid     <= 1'b0;
      dec_admit     <= 1'b0;
      drop_bc_pulse <= '0;
      drop_mc_pulse <= '0;
    end else begin
      dec_valid     <= frm_valid;
      dec_admit     <= frm_valid && !(|cls_drop);
      drop_bc_pulse <= cls_drop[0] ? port_bit : '0;
      drop_mc_pulse <= cls_drop[1] ? port_bit : '0;
    end
  end
endmodule

// File: rtl/storm_limiter_chk.sv
module storm_limiter_chk #(
  parameter int NUM_PORTS  = 4,
  parameter int PRESCALE_W = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cfg_enable,
  input logic [PRESCALE_W-1:0] cfg_prescale,
  input logic                  frm_valid,
  input logic [1:0]            frm_class,
  input logic                  dec_valid,
  input logic                  dec_admit,
  input logic [NUM_PORTS-1:0]  drop_bc_pulse,
  input logic [NUM_PORTS-1:0]  drop_mc_pulse,
  input logic                  win_tick
);
  AST_DEC_FOLLOWS: assert property (@(posedge clk) disable iff (rst) frm_valid |=> dec_valid); // R10
  AST_NO_SPURIOUS_DEC: assert property (@(posedge clk) disable iff (rst) !frm_valid |=> !dec_valid); // R10
  AST_ONE_DROP_BIT: assert property (@(posedge clk) disable iff (rst) $countones({drop_bc_pulse, drop_mc_pulse}) <= 1); // R10
  AST_DROP_IS_REJECT: assert property (@(posedge clk) disable iff (rst) (|{drop_bc_pulse, drop_mc_pulse}) |-> (dec_valid && !dec_admit)); // R10
  AST_REJECT_HAS_PULSE: assert property (@(posedge clk) disable iff (rst) (dec_valid && !dec_admit) |-> (|{drop_bc_pulse, drop_mc_pulse})); // R10
  AST_DISABLED_ADMITS: assert property (@(posedge clk) disable iff (rst) (frm_valid && !cfg_enable) |=> dec_admit); // R2
  AST_UNLIMITED_CLASS: assert property (@(posedge clk) disable iff (rst) (frm_valid && (frm_class == 2'b00 || frm_class == 2'b11)) |=> dec_admit); // R9
  AST_ZERO_PRESCALE_TICK: assert property (@(posedge clk) disable iff (rst) (cfg_prescale == '0) |-> win_tick); // R8
endmodule

bind storm_limiter storm_limiter_chk #(.NUM_PORTS(NUM_PORTS), .PRESCALE_W(PRESCALE_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_enable    (cfg_enable),
  .cfg_prescale  (cfg_prescale),
  .frm_valid     (frm_valid),
  .frm_class     (frm_class),
  .dec_valid     (dec_valid),
  .dec_admit     (dec_admit),
  .drop_bc_pulse (drop_bc_pulse),
  .drop_mc_pulse (drop_mc_pulse),
  .win_tick      (win_tick)
);

// File: tb/storm_limiter_test.sv
module storm_limiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int LW = 8;
  localparam int PW = 16;
  localparam int PORTW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_enable = 1'b0;
  logic [PW-1:0] cfg_prescale = '0;
  logic cfg_wr_en = 1'b0;
  logic [PORTW-1:0] cfg_wr_port = '0;
  logic [LW-1:0] cfg_wr_bc_limit = '0, cfg_wr_mc_limit = '0;
  logic frm_valid = 1'b0;
  logic [PORTW-1:0] frm_port = '0;
  logic [1:0] frm_class = '0;
  logic dec_valid, dec_admit;
  logic [NP-1:0] drop_bc_pulse, drop_mc_pulse;

  storm_limiter #(.NUM_PORTS(NP), .LIMIT_W(LW), .PRESCALE_W(PW)) uut (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_prescale(cfg_prescale),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_port(cfg_wr_port),
    .cfg_wr_bc_limit(cfg_wr_bc_limit), .cfg_wr_mc_limit(cfg_wr_mc_limit),
    .frm_valid(frm_valid), .frm_port(frm_port), .frm_class(frm_class),
    .dec_valid(dec_valid), .dec_admit(dec_admit),
    .drop_bc_pulse(drop_bc_pulse), .drop_mc_pulse(drop_mc_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int m_bc [NP], m_mc [NP], l_bc [NP], l_mc [NP];
  bit m_en = 1'b0;
  int m_pre = 0, cyc = 0;
  int admits_seen = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  function automatic bit is_boundary(input int k, input int pre);
    int peff;
    peff = (pre == 0) ? 1 : pre;
    return ((k + 1) % peff) == 0;
  endfunction

  task automatic do_reset(input int pre);
    @(negedge clk);
    rst = 1'b1; cfg_prescale = PW'(pre); frm_valid = 1'b0; cfg_wr_en = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(dec_valid == 1'b0, "R1", dec_valid, 0);
    chk(drop_bc_pulse == '0 && drop_mc_pulse == '0, "R1", int'({drop_bc_pulse, drop_mc_pulse}), 0);
    rst = 1'b0;
    m_pre = pre; cyc = 0; m_en = cfg_enable;
    for (int i = 0; i < NP; i++) begin m_bc[i] = 0; m_mc[i] = 0; l_bc[i] = 0; l_mc[i] = 0; end
  endtask

  task automatic set_en(input bit en);
    cfg_enable = en; m_en = en;   // called at a falling edge
  endtask

  // drive one cycle at a falling edge, check at the next falling edge
  task automatic step(input bit wr, input int wp, input int wbc, input int wmc,
                      input bit fv, input int fp, input int fc, input string tag);
    bit exp_adm;
    int e_bc, e_mc, lim, cnt;
    string t;
    cfg_wr_en = wr; cfg_wr_port = PORTW'(wp);
    cfg_wr_bc_limit = LW'(wbc); cfg_wr_mc_limit = LW'(wmc);
    frm_valid = fv; frm_port = PORTW'(fp); frm_class = 2'(fc);
    exp_adm = 1'b1; e_bc = 0; e_mc = 0;
    if (is_boundary(cyc, m_pre))
      for (int i = 0; i < NP; i++) begin m_bc[i] = 0; m_mc[i] = 0; end
    t = tag;
    if (fv && (fc == 1 || fc == 2)) begin
      lim = (fc == 1) ? l_bc[fp] : l_mc[fp];
      cnt = (fc == 1) ? m_bc[fp] : m_mc[fp];
      if (t == "") t = !m_en ? "R2" : (lim == 0) ? "R3" : is_boundary(cyc, m_pre) ? "R7" : "R4";
      if (m_en && lim != 0) begin
        if (cnt < lim) begin
          if (fc == 1) m_bc[fp]++; else m_mc[fp]++;
        end else begin
          exp_adm = 1'b0;
          if (fc == 1) e_bc = 1 << fp; else e_mc = 1 << fp;
        end
      end
    end else if (t == "") t = "R9";
    if (wr) begin l_bc[wp] = wbc; l_mc[wp] = wmc; end
    @(posedge clk);
    @(negedge clk);
    cyc++;
    chk(dec_valid == fv, "R10", dec_valid, fv);
    if (fv) begin
      chk(dec_admit == exp_adm, t, dec_admit, exp_adm);
      if (dec_admit) admits_seen++;
    end
    chk(drop_bc_pulse == NP'(e_bc), "R10", drop_bc_pulse, e_bc);
    chk(drop_mc_pulse == NP'(e_mc), "R10", drop_mc_pulse, e_mc);
    frm_valid = 1'b0; cfg_wr_en = 1'b0;
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0, "R10"); endtask

  initial begin
    int cyc_wd = 0;
    forever begin
      @(posedge clk);
      cyc_wd++;
      if (cyc_wd > 150000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc_wd, 150000);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd5150));
    // reset state and zero budgets after reset
    do_reset(40);
    set_en(1'b1);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 1, 1, "R1/R3");
    // budgets: port0 bc=3 mc=2
    step(1, 0, 3, 2, 0, 0, 0, "R10");
    // R11: write in same cycle as frame uses old budget (3)
    step(1, 0, 1, 2, 1, 0, 1, "R11");
    step(0, 0, 0, 0, 1, 0, 1, "R11");     // budget now 1, count 1 -> drop
    step(1, 0, 3, 2, 0, 0, 0, "R10");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 0, 1, "R4");  // admit, admit, drop, drop
    // R5: multicast budget separate; other port separate
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0, 2, "R5");
    step(1, 1, 1, 0, 0, 0, 0, "R10");
    for (int i = 0; i < 2; i++) step(0, 0, 0, 0, 1, 1, 1, "R5");
    step(0, 0, 0, 0, 1, 2, 1, "R5");
    step(0, 0, 0, 0, 1, 1, 2, "R3");
    // R2: global disable
    set_en(1'b0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0, 1, "R2");
    set_en(1'b1);
    // R9: unicast and other class
    step(0, 0, 0, 0, 1, 0, 0, "R9");
    step(0, 0, 0, 0, 1, 0, 3, "R9");
    step(0, 0, 0, 0, 1, 0, 1, "R4");

    // R6/R7: window of 5, budget 1, frame every cycle
    do_reset(5);
    step(1, 2, 1, 0, 0, 0, 0, "R10");
    admits_seen = 0;
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 1, 2, 1, "R6/R7");
    chk(admits_seen == 5, "R6", admits_seen, 5);

    // R8: zero prescale
    do_reset(0);
    step(1, 3, 0, 1, 0, 0, 0, "R10");
    admits_seen = 0;
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 1, 3, 2, "R8");
    chk(admits_seen == 10, "R8", admits_seen, 10);

    // random mix
    do_reset(7);
    set_en(1'b1);
    for (int i = 0; i < 3000; i++) begin
      bit wr, fv;
      wr = ($urandom % 8) == 0;
      fv = ($urandom % 10) < 7;
      if (($urandom % 50) == 0) set_en(~m_en);
      step(wr, $urandom % NP, (($urandom % 6) == 0) ? 255 : $urandom % 5, $urandom % 5,
           fv, $urandom % NP, $urandom % 4, "");
    end
    do_reset(0);
    set_en(1'b1);
    for (int i = 0; i < 500; i++)
      step(($urandom % 6) == 0, $urandom % NP, $urandom % 3, $urandom % 3,
           ($urandom % 10) < 8, $urandom % NP, $urandom % 4, "");
    idle();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule